// File: doc/BRIEF.md
# Asynchronous PWM Timer Channel

One pulse-width-modulated output channel. The waveform comes from a period counter that runs on its own counter clock, behind a prescaler. The channel is configured through a small register bus clocked by an independent bus clock. The two clocks may have any frequency relationship. Software sets a cycle length, a low-phase length, a prescaler step, a polarity bit and an enable bit. A four-phase handshake carries these settings into the counter domain as one set. The counter adopts the new set only at the end of a period, so no period is ever cut short or glitched.

In native polarity each period starts with the low phase and then goes high. Setting the invert bit swaps the two levels. A constant output level is reached by programming a low length of zero, or a low length greater than the cycle value. The second case needs the cycle value to stay below its all-ones maximum. Three events are captured as sticky status bits in the bus domain: an output rising edge, an output falling edge and the counter clearing. Each bit can be masked onto a single interrupt line.

Top module: `async_pwm_channel`

## Requirements
- R1: With the channel enabled, the counter steps from 0 up to the cycle value (address 1, bits [CNT_W-1:0]) inclusive, then returns to 0. A period therefore lasts (cycle+1) prescaled ticks, and each return to 0 is a clear event.
- R2: The prescaler select in control bits [3:2] picks a tick every 1, 16, 256 or 2048 counter clocks for the values 0, 1, 2 and 3.
- R3: In native polarity the output is 0 while the count is below the low length (address 2) and 1 otherwise. The output therefore stays high for (cycle+1-low) ticks of every period.
- R4: Control bit 1 set inverts the output level at every count.
- R5: A low length greater than the cycle value holds the output at the first-phase level. A low length of 0 holds it at the opposite level. In both cases no rising or falling event occurs.
- R6: With the active enable (control bit 0) at 0, the counter is held at 0 and the output sits at the idle level, which equals the invert bit. No edge events occur.
- R7: A configuration written while the channel runs takes effect only at the next counter clear. The period in progress completes with the old settings.
- R8: Status at address 3 holds rise (bit 0), fall (bit 1) and clear (bit 2). These bits are sticky and are cleared by writing 1. The mask register at address 4 uses the same bit order. irq_o is the OR of the status bits ANDed with their mask bits.
- R9: The waveform is correct both when the counter clock is slower than the bus clock and when it is faster.
- R10: Whenever 0 < low <= cycle, every period produces one rising event and one falling event of the output.
- R11: The control, cycle and low registers read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk_i | input | 1 | Register bus clock |
| cnt_clk_i | input | 1 | Counter clock, asynchronous to the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Write strobe, one bus cycle |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench builds the channel with CNT_W = 5. This shrinks the cycle range to 0..31, so every low length from 0 to cycle+1 can be swept for a ladder of cycle values, in both polarities. Because the count stays short, each prescaler step up to 2048 can be measured over whole periods. The out-of-range low length that yields a constant level is also easy to reach. The sweep is repeated with the counter clock slower than the bus clock and again with it faster. High time and edge counts are compared with values computed arithmetically from the cycle, low and divider.

// File: rtl/apwm_pkg.sv
`timescale 1ns/1ps
package apwm_pkg;
  localparam int PRE_W  = 11;
  localparam int NUM_EV = 3;
  localparam int EV_RISE = 0;
  localparam int EV_FALL = 1;
  localparam int EV_CLR  = 2;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_CYCLE = 3'd1;
  localparam logic [2:0] A_LOW   = 3'd2;
  localparam logic [2:0] A_STAT  = 3'd3;
  localparam logic [2:0] A_MASK  = 3'd4;

  // last prescaler count before a tick
  function automatic logic [PRE_W-1:0] div_last(input logic [1:0] sel);
    case (sel)
      2'd0:    div_last = PRE_W'(0);
      2'd1:    div_last = PRE_W'(15);
      2'd2:    div_last = PRE_W'(255);
      default: div_last = PRE_W'(2047);
    endcase
  endfunction
endpackage

// File: rtl/apwm_cfg_cdc.sv
`timescale 1ns/1ps
module apwm_cfg_cdc #(
  parameter int W = 8
) (
  input  logic         bus_clk_i,
  input  logic         cnt_clk_i,
  input  logic         rst_ni,
  input  logic         launch_i,
  input  logic [W-1:0] data_i,
  output logic         start_o,
  output logic         cap_o,
  output logic [W-1:0] data_o
);
  logic         req_q;
  logic [1:0]   ack_s;
  logic [W-1:0] xfer_q;
  logic [2:0]   req_s;

  // new transfer only after the previous four-phase cycle fully returned to idle
  assign start_o = launch_i && !req_q && !ack_s[1];

  always_ff @(posedge bus_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      ack_s  <= '0;
      xfer_q <= '0;
    end else begin
      ack_s <= {ack_s[0], req_s[2]};
      if (start_o) begin
        xfer_q <= data_i;
        req_q  <= 1'b1;
      end else if (req_q && ack_s[1]) begin
        req_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge cnt_clk_i or negedge rst_ni) begin
    if (!rst_ni) req_s <= '0;
    else         req_s <= {req_s[1:0], req_q};
  end

  assign cap_o  = req_s[1] && !req_s[2];
  assign data_o = xfer_q;
endmodule

// File: rtl/apwm_evt_sync.sv
`timescale 1ns/1ps
module apwm_evt_sync #(
  parameter int N = 3
) (
  input  logic         src_clk_i,
  input  logic         dst_clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pulse_i,
  output logic [N-1:0] pulse_o
);
  for (genvar i = 0; i < N; i++) begin : g_ev
    logic       tgl_q;
    logic [2:0] sync_q;

    always_ff @(posedge src_clk_i or negedge rst_ni) begin
      if (!rst_ni)         tgl_q <= 1'b0;
      else if (pulse_i[i]) tgl_q <= ~tgl_q;
    end

    always_ff @(posedge dst_clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[1:0], tgl_q};
    end

    assign pulse_o[i] = sync_q[2] ^ sync_q[1];
  end
endmodule

// File: rtl/apwm_core.sv
`timescale 1ns/1ps
module apwm_core
  import apwm_pkg::*;
#(
  parameter int CNT_W = 24,
  localparam int CFG_W = 4 + 2*CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             pwm_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             clr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             act_en_o,
  output logic             act_inv_o,
  output logic [CNT_W-1:0] act_cyc_o
);
  // cfg layout: {en, inv, sel[1:0], cycle, low}
  localparam int LOW_LSB = 0;
  localparam int CYC_LSB = CNT_W;
  localparam int SEL_LSB = 2*CNT_W;
  localparam int INV_BIT = 2*CNT_W + 2;
  localparam int EN_BIT  = 2*CNT_W + 3;

  logic [CFG_W-1:0] pend_q, act_q;
  logic             pend_v_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pwm_q;

  logic             act_en, act_inv;
  logic [1:0]       act_sel;
  logic [CNT_W-1:0] act_cyc, act_low;
  logic             tick, wrap, apply, pwm_nxt;

  assign act_en  = act_q[EN_BIT];
  assign act_inv = act_q[INV_BIT];
  assign act_sel = act_q[SEL_LSB +: 2];
  assign act_cyc = act_q[CYC_LSB +: CNT_W];
  assign act_low = act_q[LOW_LSB +: CNT_W];

  assign tick  = act_en && (pre_q == div_last(act_sel));
  assign wrap  = tick && (cnt_q == act_cyc);
  assign apply = pend_v_q && (!act_en || wrap);

  // native order: low phase first
  assign pwm_nxt = act_en ? ((cnt_q >= act_low) ^ act_inv) : act_inv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      act_q    <= '0;
      pre_q    <= '0;
      cnt_q    <= '0;
      pwm_q    <= 1'b0;
    end else begin
      if (cap_i) begin
        pend_q   <= cfg_i;
        pend_v_q <= 1'b1;
      end else if (apply) begin
        pend_v_q <= 1'b0;
      end
      if (apply) act_q <= pend_q;

      if (!act_en || tick) pre_q <= '0;
      else                 pre_q <= pre_q + 1'b1;

      if (!act_en || wrap) cnt_q <= '0;
      else if (tick)       cnt_q <= cnt_q + 1'b1;

      pwm_q <= pwm_nxt;
    end
  end

  assign pwm_o     = pwm_q;
  assign rise_o    = pwm_nxt && !pwm_q;
  assign fall_o    = !pwm_nxt && pwm_q;
  assign clr_o     = wrap;
  assign cnt_o     = cnt_q;
  assign act_en_o  = act_en;
  assign act_inv_o = act_inv;
  assign act_cyc_o = act_cyc;
endmodule

// File: rtl/async_pwm_channel.sv
`timescale 1ns/1ps
module async_pwm_channel
  import apwm_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic        bus_clk_i,
  input  logic        cnt_clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  reg_addr_i,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        pwm_o,
  output logic        irq_o
);
  localparam int CFG_W = 4 + 2*CNT_W;

  logic             en_q, inv_q;
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] cyc_q, low_q;
  logic             dirty_q, wr_cfg, start;
  logic [NUM_EV-1:0] stat_q, mask_q, ev_cnt, ev_bus, stat_clr;

  logic             cap;
  logic [CFG_W-1:0] cfg_x;
  logic             rise, fall, clr;
  logic [CNT_W-1:0] cnt_w, act_cyc_w;
  logic             act_en_w, act_inv_w;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[31:CNT_W];

  assign wr_cfg   = reg_we_i && (reg_addr_i == A_CTRL || reg_addr_i == A_CYCLE ||
                                 reg_addr_i == A_LOW);
  assign stat_clr = (reg_we_i && reg_addr_i == A_STAT) ? reg_wdata_i[NUM_EV-1:0] : '0;

  always_ff @(posedge bus_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      inv_q   <= 1'b0;
      sel_q   <= '0;
      cyc_q   <= '0;
      low_q   <= '0;
      mask_q  <= '0;
      stat_q  <= '0;
      dirty_q <= 1'b0;
    end else begin
      if (reg_we_i) begin
        case (reg_addr_i)
          A_CTRL: begin
            en_q  <= reg_wdata_i[0];
            inv_q <= reg_wdata_i[1];
            sel_q <= reg_wdata_i[3:2];
          end
          A_CYCLE: cyc_q  <= reg_wdata_i[CNT_W-1:0];
          A_LOW:   low_q  <= reg_wdata_i[CNT_W-1:0];
          A_MASK:  mask_q <= reg_wdata_i[NUM_EV-1:0];
          default: ;
        endcase
      end
      // a write racing a launch keeps dirty set so it is sent again
      dirty_q <= (dirty_q && !start) || wr_cfg;
      stat_q  <= (stat_q & ~stat_clr) | ev_bus;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o[3:0]         = {sel_q, inv_q, en_q};
      A_CYCLE: reg_rdata_o[CNT_W-1:0]   = cyc_q;
      A_LOW:   reg_rdata_o[CNT_W-1:0]   = low_q;
      A_STAT:  reg_rdata_o[NUM_EV-1:0]  = stat_q;
      A_MASK:  reg_rdata_o[NUM_EV-1:0]  = mask_q;
      default: ;
    endcase
  end

  assign irq_o = |(stat_q & mask_q);

  apwm_cfg_cdc #(.W(CFG_W)) u_cdc (
    .bus_clk_i (bus_clk_i),
    .cnt_clk_i (cnt_clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (dirty_q),
    .data_i    ({en_q, inv_q, sel_q, cyc_q, low_q}),
    .start_o   (start),
    .cap_o     (cap),
    .data_o    (cfg_x)
  );

  apwm_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (cnt_clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .cfg_i     (cfg_x),
    .pwm_o     (pwm_o),
    .rise_o    (rise),
    .fall_o    (fall),
    .clr_o     (clr),
    .cnt_o     (cnt_w),
    .act_en_o  (act_en_w),
    .act_inv_o (act_inv_w),
    .act_cyc_o (act_cyc_w)
  );

  always_comb begin
    ev_cnt          = '0;
    ev_cnt[EV_RISE] = rise;
    ev_cnt[EV_FALL] = fall;
    ev_cnt[EV_CLR]  = clr;
  end

  apwm_evt_sync #(.N(NUM_EV)) u_evt (
    .src_clk_i (cnt_clk_i),
    .dst_clk_i (bus_clk_i),
    .rst_ni    (rst_ni),
    .pulse_i   (ev_cnt),
    .pulse_o   (ev_bus)
  );
endmodule

// File: rtl/async_pwm_channel_chk.sv
`timescale 1ns/1ps
module async_pwm_channel_chk #(
  parameter int CNT_W = 24
) (
  input logic             cnt_clk_i,
  input logic             bus_clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W-1:0] act_cyc_w,
  input logic             act_en_w,
  input logic             act_inv_w,
  input logic             clr,
  input logic             pwm_o,
  input logic             irq_o,
  input logic             reg_we_i
);
  assert_held_when_off_R6: assert property (@(posedge cnt_clk_i) disable iff (!rst_ni)
    !act_en_w |-> cnt_w == '0);

  assert_idle_level_R6: assert property (@(posedge cnt_clk_i) disable iff (!rst_ni)
    !act_en_w |=> pwm_o == $past(act_inv_w));

  assert_cnt_in_range_R1: assert property (@(posedge cnt_clk_i) disable iff (!rst_ni)
    act_en_w |-> cnt_w <= act_cyc_w);

  assert_cnt_step_R1: assert property (@(posedge cnt_clk_i) disable iff (!rst_ni)
    act_en_w && !clr |=> (cnt_w == $past(cnt_w)) || (cnt_w == $past(cnt_w) + 1'b1));

  assert_clear_to_zero_R1: assert property (@(posedge cnt_clk_i) disable iff (!rst_ni)
    clr |=> cnt_w == '0);

  assert_irq_sticky_R8: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    irq_o && !reg_we_i |=> irq_o);
endmodule

bind async_pwm_channel async_pwm_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .cnt_clk_i (cnt_clk_i),
  .bus_clk_i (bus_clk_i),
  .rst_ni    (rst_ni),
  .cnt_w     (cnt_w),
  .act_cyc_w (act_cyc_w),
  .act_en_w  (act_en_w),
  .act_inv_w (act_inv_w),
  .clr       (clr),
  .pwm_o     (pwm_o),
  .irq_o     (irq_o),
  .reg_we_i  (reg_we_i)
);

// File: tb/async_pwm_channel_tb_top.sv
`timescale 1ns/1ps
module async_pwm_channel_tb_top;
  localparam int CNT_W = 5;
  localparam int WDOG  = 190000;

  logic        bclk = 1'b0, cclk = 1'b0, rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        pwm, irq;
  real         c_half = 3.5;
  int          tests = 0, fails = 0, bcyc = 0;
  int          prev_per = 1;

  always #2.5 bclk = ~bclk;
  always #(c_half) cclk = ~cclk;

  async_pwm_channel #(.CNT_W(CNT_W)) dut_i (
    .bus_clk_i(bclk), .cnt_clk_i(cclk), .rst_ni(rst_n),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .pwm_o(pwm), .irq_o(irq));

  always @(posedge bclk) begin
    bcyc++;
    if (bcyc == WDOG) begin
      tests++; fails++;
      $display("FAIL watchdog: act=%0d exp=%0d", bcyc, WDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge bclk); addr = a; wdata = d; we = 1'b1;
    @(negedge bclk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge bclk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_c(input int n);
    repeat (n) @(negedge cclk);
  endtask

  function automatic int divf(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 16 : (sel == 2) ? 256 : 2048;
  endfunction

  task automatic setup(input int sel, input int inv, input int cyc, input int low);
    int per;
    per = (cyc + 1) * divf(sel);
    wr(3'd1, cyc);
    wr(3'd2, low);
    wr(3'd0, (sel << 2) | (inv << 1) | 1);
    wait_c(2 * ((per > prev_per) ? per : prev_per) + 80);
    prev_per = per;
  endtask

  // measure over nper whole periods: high samples and level changes
  task automatic measure(input string req, input int sel, input int inv,
                         input int cyc, input int low, input int nper);
    int per, hi_t, exp_hi, exp_ed, hi, ed, lowc;
    logic prv;
    per  = (cyc + 1) * divf(sel);
    lowc = (low > cyc + 1) ? cyc + 1 : low;
    hi_t = inv ? lowc : (cyc + 1 - lowc);
    exp_hi = nper * hi_t * divf(sel);
    exp_ed = (low > 0 && low <= cyc) ? 2 * nper : 0;
    hi = 0; ed = 0;
    @(negedge cclk); prv = pwm;
    for (int i = 0; i < nper * per; i++) begin
      if (prv) hi++;
      @(negedge cclk);
      if (pwm != prv) ed++;
      prv = pwm;
    end
    check(hi == exp_hi, {req, " high time"}, hi, exp_hi);
    check(ed == exp_ed, {req, " edge count"}, ed, exp_ed);
  endtask

  initial begin
    int d;
    int cycs[6] = '{0, 1, 2, 4, 7, 30};
    #23 rst_n = 1'b1;
    wait_c(4);

    // reset state
    check(pwm == 1'b0, "R6 reset pwm idle", pwm, 0);
    check(irq == 1'b0, "R8 reset irq", irq, 0);
    rd(3'd0, d); check(d == 0, "R11 reset ctrl", d, 0);

    // readback
    wr(3'd1, 13); wr(3'd2, 6); wr(3'd0, 32'b1110);
    rd(3'd1, d); check(d == 13, "R11 cycle readback", d, 13);
    rd(3'd2, d); check(d == 6,  "R11 low readback", d, 6);
    rd(3'd0, d); check(d == 14, "R11 ctrl readback", d, 14);
    wait_c(40);
    check(pwm == 1'b1, "R6 disabled inverted idle", pwm, 1);
    wr(3'd0, 0); wait_c(40);
    check(pwm == 1'b0, "R6 disabled native idle", pwm, 0);

    // sweep: counter clock slower than bus clock
    foreach (cycs[k]) begin
      for (int low = 0; low <= cycs[k] + 1; low++) begin
        for (int inv = 0; inv < 2; inv++) begin
          setup(0, inv, cycs[k], low);
          measure("R1 R3 R4 R5 R9", 0, inv, cycs[k], low, 2);
        end
      end
    end

    // prescaler steps
    for (int sel = 1; sel < 4; sel++) begin
      setup(sel, 0, 3, 1);
      measure("R2", sel, 0, 3, 1, 1);
    end

    // events and status
    setup(0, 0, 7, 3);
    wr(3'd3, 7); wait_c(60);
    rd(3'd3, d); check(d == 7, "R10 R1 rise fall clear seen", d, 7);
    check(irq == 1'b0, "R8 masked irq low", irq, 0);
    wr(3'd4, 4); @(negedge bclk);
    check(irq == 1'b1, "R8 unmasked irq high", irq, 1);
    wr(3'd0, 0); wait_c(40); wr(3'd3, 7); wait_c(60);
    rd(3'd3, d); check(d == 0, "R8 R6 w1c and no events when off", d, 0);
    check(irq == 1'b0, "R8 irq after w1c", irq, 0);
    wr(3'd0, 1); wait_c(60); wr(3'd0, 0); wait_c(60);
    rd(3'd3, d); check(d == 7, "R8 sticky after stop", d, 7);
    wr(3'd4, 0);
    prev_per = 8;
    setup(0, 0, 7, 9);
    wr(3'd3, 7); wait_c(60);
    rd(3'd3, d); check(d == 4, "R5 no edge events, clear only", d, 4);

    // deferred apply
    setup(1, 0, 30, 31);
    wr(3'd3, 7);
    d = 0;
    while ((d & 4) == 0) rd(3'd3, d);
    wr(3'd2, 0);
    wait_c(100);
    check(pwm == 1'b0, "R7 old setting holds mid period", pwm, 0);
    wait_c(600);
    check(pwm == 1'b1, "R7 new setting after clear", pwm, 1);

    // counter clock faster than bus clock
    c_half = 1.5;
    for (int low = 0; low <= 8; low++) begin
      setup(0, low & 1, 7, low);
      measure("R9 R3 R4", 0, low & 1, 7, low, 2);
    end
    setup(1, 1, 4, 2);
    measure("R9 R2", 1, 1, 4, 2, 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule